// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block is the controller side of a three-wire serial EEPROM that stores 16-bit words. A host gives it an operation code, a word address and a data word, then pulses `start`. The block raises chip select and builds the serial frame: a start bit, a two-bit device opcode, the address field and, where the command carries one, a data word. It sends the whole frame most significant bit first on the data-in line, paced by a shift clock that it derives from the system clock. For a read it clocks the word back from the device. For a command that programs the array it lowers chip select, raises it again, and polls the device's ready status until the device reports ready or a cycle limit runs out.

All seven device instructions are built from the host operation code. These are read, write, erase, write-enable, write-disable, erase-all and write-all. The last four travel under device opcode 00, and the top two bits of the address field select which one. The address width is a parameter and may be 6 or 8 bits. The shift-clock half period, the minimum chip-select low gap, the status settling delay and the poll limit are also parameters. When the operation ends, `done` pulses for one cycle. `timeout_err` records whether the busy poll gave up.

Top module: `mw_eeprom_master`

## Requirements
- R1: Every frame starts with a 1 and continues with the opcode, then the address field MSB first, then any data word with bit 15 first. The host `op` values map to device frames as follows. 0 is read (opcode 10 and address). 1 is write (opcode 01, address and data). 2 is erase (opcode 11 and address). 3 is write-enable (opcode 00 with address field 11 followed by zeros). 4 and 7 are write-disable (opcode 00 with address field 00 followed by zeros). 5 is erase-all (opcode 00 with address field 10 followed by zeros). 6 is write-all (opcode 00 with address field 01 followed by zeros, then data).
- R2: `ee_sk` stays high for exactly SK_HALF cycles per pulse and is low whenever `ee_cs` is low. `ee_di` changes only while `ee_sk` is low. `ee_do` is sampled when `ee_sk` rises.
- R3: A read gives 17 shift-clock pulses after the address. The first bit sampled (the device's dummy 0) is discarded, and the next 16 bits, MSB first, form `rdata`. `rdata` keeps its value until the next read completes.
- R4: After the frame of a write, erase, erase-all or write-all, `ee_cs` goes low for at least CS_GAP cycles and then high again. `ee_do` is checked every cycle from SETTLE cycles after that rise, and the operation ends when it reads 1.
- R5: If ready is not seen within POLL_LIMIT cycles of the status rise of `ee_cs`, the block lowers `ee_cs` and finishes with `timeout_err` set to 1. `timeout_err` is cleared when the next operation is accepted.
- R6: Before `done`, `ee_cs` stays low for at least CS_GAP cycles. Every rise of `ee_cs` follows at least CS_GAP low cycles. `done` is a single-cycle pulse that coincides with `busy` falling.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It produces no frame and no extra `done`.
- R8: Read, write-enable and write-disable end without a status poll, so `ee_cs` rises only once for them.
- R9: ADDR_W must be 6 or 8, and other values stop elaboration. A frame is 3+ADDR_W bits long, or 19+ADDR_W bits when it carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| op | input | 3 | Host operation code (see R1) |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Data word for write and write-all |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last programming poll timed out |
| rdata | output | 16 | Word from the most recent read |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sk | output | 1 | Device shift clock |
| ee_di | output | 1 | Serial data into the device |
| ee_do | input | 1 | Serial data and ready status from the device |

## Verification
The bench builds the block with ADDR_W=8, SK_HALF=3, CS_GAP=5, SETTLE=2 and POLL_LIMIT=300. The 8-bit address reaches the top word 0xFF and the 27-bit data frames. The odd half period selects the compare-and-clear divider variant. The 300-cycle limit lets a device model that never reports ready drive the timeout path within a short run. The responder model executes each instruction, including the write-enable gate, so reads taken after writes, erases and the array-wide commands confirm the frames end to end.

// File: rtl/mw_pkg.sv
package mw_pkg;

   localparam int unsigned WORD_W = 16;

   typedef enum logic [2:0] {
      HOP_READ  = 3'd0,
      HOP_WRITE = 3'd1,
      HOP_ERASE = 3'd2,
      HOP_WEN   = 3'd3,
      HOP_WDS   = 3'd4,
      HOP_ERAL  = 3'd5,
      HOP_WRAL  = 3'd6,
      HOP_RSV   = 3'd7
   } host_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_RDATA,
      ST_GAP_POLL,
      ST_POLL,
      ST_GAP_END
   } seq_state_e;

endpackage

// File: rtl/mw_sk_div.sv
module mw_sk_div #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   localparam int CW  = (HALF > 1) ? $clog2(HALF) : 1;
   localparam bit POW2 = ((HALF & (HALF - 1)) == 0);

   if (HALF < 2) begin : g_bad_half
      $error("mw_sk_div: HALF must be at least 2");
   end

   logic [CW-1:0] cnt;

   if (POW2) begin : g_wrap
      // counter wraps naturally at the half period
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (!en) cnt <= '0;
         else          cnt <= cnt + CW'(1);
      end
      assign tick = en && (&cnt);
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt <= '0;
         else if (!en)                      cnt <= '0;
         else if (cnt == CW'(HALF - 1))     cnt <= '0;
         else                               cnt <= cnt + CW'(1);
      end
      assign tick = en && (cnt == CW'(HALF - 1));
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

endmodule

// File: rtl/mw_cmd_build.sv
module mw_cmd_build
   import mw_pkg::*;
#(
   parameter int AW  = 6,
   parameter int FW  = 19 + AW,
   parameter int NBW = $clog2(FW + 1)
) (
   input  logic [2:0]        op,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [FW-1:0]     frame,
   output logic [NBW-1:0]    nbits,
   output logic              is_read,
   output logic              is_prog
);

   localparam int PAD = AW - 2;

   if (AW != 6 && AW != 8) begin : g_bad_aw
      $error("mw_cmd_build: address width must be 6 or 8");
   end

   function automatic logic [AW-1:0] sub_field(input logic [1:0] sel);
      return {sel, {PAD{1'b0}}};
   endfunction

   logic [1:0]        opc;
   logic [AW-1:0]     afield;
   logic [WORD_W-1:0] dfield;
   logic              has_data;

   always_comb begin
      opc      = 2'b00;
      afield   = addr;
      dfield   = '0;
      has_data = 1'b0;
      is_read  = 1'b0;
      is_prog  = 1'b0;
      case (host_op_e'(op))
         HOP_READ:  begin opc = 2'b10; is_read = 1'b1; end
         HOP_WRITE: begin opc = 2'b01; dfield = wdata; has_data = 1'b1; is_prog = 1'b1; end
         HOP_ERASE: begin opc = 2'b11; is_prog = 1'b1; end
         HOP_WEN:   afield = sub_field(2'b11);
         HOP_ERAL:  begin afield = sub_field(2'b10); is_prog = 1'b1; end
         HOP_WRAL:  begin afield = sub_field(2'b01); dfield = wdata; has_data = 1'b1; is_prog = 1'b1; end
         default:   afield = sub_field(2'b00);
      endcase
      frame = {1'b1, opc, afield, dfield};
      nbits = has_data ? NBW'(FW) : NBW'(FW - WORD_W);
   end

endmodule

// File: rtl/mw_seq.sv
module mw_seq
   import mw_pkg::*;
#(
   parameter int AW         = 6,
   parameter int FW         = 19 + AW,
   parameter int NBW        = $clog2(FW + 1),
   parameter int CS_GAP     = 24,
   parameter int SETTLE     = 25,
   parameter int POLL_LIMIT = 600000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FW-1:0]     frame,
   input  logic [NBW-1:0]    nbits,
   input  logic              is_read,
   input  logic              is_prog,
   input  logic              tick,
   input  logic              ee_do,
   output logic              sk_en,
   output logic              cs,
   output logic              sk,
   output logic              di,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [WORD_W-1:0] rdata
);

   localparam int GW = $clog2(CS_GAP + 1);
   localparam int PW = $clog2(POLL_LIMIT + 1);
   localparam logic [4:0] RD_PULSES = 5'(WORD_W + 1);

   seq_state_e        st;
   logic [FW-1:0]     sreg;
   logic [NBW-1:0]    bits_left;
   logic [4:0]        rd_left;
   logic [WORD_W-1:0] rsh;
   logic [GW-1:0]     gcnt;
   logic [PW-1:0]     pcnt;
   logic              rd_q, prog_q;

   assign di    = sreg[FW-1];
   assign busy  = (st != ST_IDLE);
   assign sk_en = (st == ST_SHIFT) || (st == ST_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sreg      <= '0;
         bits_left <= '0;
         rd_left   <= '0;
         rsh       <= '0;
         gcnt      <= '0;
         pcnt      <= '0;
         rd_q      <= 1'b0;
         prog_q    <= 1'b0;
         cs        <= 1'b0;
         sk        <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               sreg      <= frame;
               bits_left <= nbits;
               rd_q      <= is_read;
               prog_q    <= is_prog;
               cs        <= 1'b1;
               sk        <= 1'b0;
               err       <= 1'b0;
               st        <= ST_SHIFT;
            end
            ST_SHIFT: if (tick) begin
               if (!sk) begin
                  sk <= 1'b1;
               end else begin
                  sk <= 1'b0;
                  if (bits_left == NBW'(1)) begin
                     sreg <= '0;
                     gcnt <= '0;
                     if (rd_q) begin
                        rd_left <= RD_PULSES;
                        st      <= ST_RDATA;
                     end else begin
                        cs <= 1'b0;
                        st <= prog_q ? ST_GAP_POLL : ST_GAP_END;
                     end
                  end else begin
                     sreg      <= {sreg[FW-2:0], 1'b0};
                     bits_left <= bits_left - NBW'(1);
                  end
               end
            end
            ST_RDATA: if (tick) begin
               if (!sk) begin
                  sk  <= 1'b1;
                  rsh <= {rsh[WORD_W-2:0], ee_do};
               end else begin
                  sk <= 1'b0;
                  if (rd_left == 5'd1) begin
                     rdata <= rsh;
                     cs    <= 1'b0;
                     gcnt  <= '0;
                     st    <= ST_GAP_END;
                  end else begin
                     rd_left <= rd_left - 5'd1;
                  end
               end
            end
            ST_GAP_POLL: begin
               if (gcnt == GW'(CS_GAP - 1)) begin
                  cs   <= 1'b1;
                  pcnt <= '0;
                  st   <= ST_POLL;
               end else begin
                  gcnt <= gcnt + GW'(1);
               end
            end
            ST_POLL: begin
               if (pcnt >= PW'(SETTLE) && ee_do) begin
                  cs   <= 1'b0;
                  gcnt <= '0;
                  st   <= ST_GAP_END;
               end else if (pcnt == PW'(POLL_LIMIT - 1)) begin
                  err  <= 1'b1;
                  cs   <= 1'b0;
                  gcnt <= '0;
                  st   <= ST_GAP_END;
               end else begin
                  pcnt <= pcnt + PW'(1);
               end
            end
            ST_GAP_END: begin
               if (gcnt == GW'(CS_GAP - 1)) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else begin
                  gcnt <= gcnt + GW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // consecutive cycles with chip select low, saturating at CS_GAP
   logic [GW-1:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_cnt <= GW'(CS_GAP);
      else if (cs)                      low_cnt <= '0;
      else if (low_cnt < GW'(CS_GAP))   low_cnt <= low_cnt + GW'(1);
   end

   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) |-> (low_cnt >= GW'(CS_GAP))); // R6
   AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sk); // R2
   AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sk |-> $stable(di)); // R2
   AST_FRAME_LEADS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (cs && di)); // R1
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R6
   AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(st == ST_POLL)); // R5
   AST_READ_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDATA) |=> (st != ST_GAP_POLL && st != ST_POLL)); // R8

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
   import mw_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int SK_HALF    = 4,
   parameter int CS_GAP     = 24,
   parameter int SETTLE     = 25,
   parameter int POLL_LIMIT = 600000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic              busy,
   output logic              done,
   output logic              timeout_err,
   output logic [15:0]       rdata,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);

   localparam int FW  = 3 + ADDR_W + WORD_W;
   localparam int NBW = $clog2(FW + 1);

   if (ADDR_W != 6 && ADDR_W != 8) begin : g_bad_addr_w
      $error("mw_eeprom_master: ADDR_W must be 6 or 8"); // R9
   end
   if (CS_GAP < 1 || SETTLE >= POLL_LIMIT) begin : g_bad_timing
      $error("mw_eeprom_master: need CS_GAP >= 1 and SETTLE < POLL_LIMIT");
   end

   logic [FW-1:0]  frame;
   logic [NBW-1:0] nbits;
   logic           is_read, is_prog, tick, sk_en;

   mw_cmd_build #(.AW(ADDR_W), .FW(FW), .NBW(NBW)) u_build (
      .op      (op),
      .addr    (addr),
      .wdata   (wdata),
      .frame   (frame),
      .nbits   (nbits),
      .is_read (is_read),
      .is_prog (is_prog)
   );

   mw_sk_div #(.HALF(SK_HALF)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sk_en),
      .tick  (tick)
   );

   mw_seq #(
      .AW(ADDR_W), .FW(FW), .NBW(NBW),
      .CS_GAP(CS_GAP), .SETTLE(SETTLE), .POLL_LIMIT(POLL_LIMIT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .frame   (frame),
      .nbits   (nbits),
      .is_read (is_read),
      .is_prog (is_prog),
      .tick    (tick),
      .ee_do   (ee_do),
      .sk_en   (sk_en),
      .cs      (ee_cs),
      .sk      (ee_sk),
      .di      (ee_di),
      .busy    (busy),
      .done    (done),
      .err     (timeout_err),
      .rdata   (rdata)
   );

endmodule

// File: tb/mw_eeprom_master_tb_top.sv
module mw_eeprom_master_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int HALF  = 3;
   localparam int GAP   = 5;
   localparam int SETL  = 2;
   localparam int LIMIT = 300;
   localparam int BUSY_CYC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] op_i = '0;
   logic [AW-1:0] addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic busy, done, timeout_err, ee_cs, ee_sk, ee_di;
   logic [15:0] rdata;
   logic ee_do = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mw_eeprom_master #(
      .ADDR_W(AW), .SK_HALF(HALF), .CS_GAP(GAP), .SETTLE(SETL), .POLL_LIMIT(LIMIT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .addr(addr_i),
      .wdata(wdata_i), .busy(busy), .done(done), .timeout_err(timeout_err),
      .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   // ---------------- device responder ----------------
   logic [15:0] mem [256];
   logic [31:0] rx, last_rx;
   int rx_n, last_n, rd_idx, pend, cs_rises, hi_run, sk_viol, di_viol;
   logic rd_on, wen, p_sk, p_cs, p_di, stuck;
   logic [15:0] rd_word, r_d;
   logic [1:0] r_opc;
   logic [AW-1:0] r_a;
   logic r_long, r_ok;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = 16'(i) ^ 16'hA5C3;
         rx = '0; last_rx = '0; rx_n = 0; last_n = 0; rd_idx = 0; pend = 0;
         cs_rises = 0; hi_run = 0; sk_viol = 0; di_viol = 0;
         rd_on = 1'b0; wen = 1'b0; p_sk = 1'b0; p_cs = 1'b0; p_di = 1'b0;
         ee_do = 1'b0;
      end else begin
         if (pend > 0) pend--;
         if (ee_cs && !p_cs) begin rx = '0; rx_n = 0; rd_on = 1'b0; cs_rises++; end
         if (ee_cs && ee_sk && !p_sk && !rd_on) begin
            rx = {rx[30:0], ee_di}; rx_n++;
            if (rx_n == 3 + AW && rx[AW+1:AW] == 2'b10) begin
               rd_on = 1'b1; rd_idx = 0; rd_word = mem[rx[AW-1:0]];
            end
         end
         if (ee_cs && !ee_sk && p_sk && rd_on) begin
            if (rd_idx == 0) ee_do = 1'b0;
            else if (rd_idx <= 16) ee_do = rd_word[16-rd_idx];
            rd_idx++;
         end
         if (!ee_cs && p_cs) begin
            if (rx_n > 0) begin
               last_rx = rx; last_n = rx_n;
               r_ok = 1'b1; r_long = 1'b0; r_d = '0;
               if (rx_n == 3 + AW) begin
                  r_opc = rx[AW+1:AW]; r_a = rx[AW-1:0];
               end else if (rx_n == 19 + AW) begin
                  r_opc = rx[AW+17:AW+16]; r_a = rx[AW+15:16]; r_d = rx[15:0]; r_long = 1'b1;
               end else begin
                  r_ok = 1'b0; r_opc = 2'b10; r_a = '0;
               end
               if (r_ok) begin
                  case (r_opc)
                     2'b01: if (r_long) begin if (wen) mem[r_a] = r_d; pend = BUSY_CYC; end
                     2'b11: begin if (wen) mem[r_a] = 16'hFFFF; pend = BUSY_CYC; end
                     2'b00: case (r_a[AW-1:AW-2])
                        2'b11: wen = 1'b1;
                        2'b00: wen = 1'b0;
                        2'b10: begin
                           if (wen) for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
                           pend = BUSY_CYC;
                        end
                        default: if (r_long) begin
                           if (wen) for (int i = 0; i < 256; i++) mem[i] = r_d;
                           pend = BUSY_CYC;
                        end
                     endcase
                     default: ;
                  endcase
               end
            end
            rd_on = 1'b0; ee_do = 1'b0;
         end
         if (ee_cs && rx_n == 0 && !rd_on) ee_do = (pend == 0) && !stuck;
         // shift-clock shape monitor (R2)
         if (ee_sk) hi_run++;
         if (p_sk && !ee_sk) begin
            if (hi_run != HALF) sk_viol++;
            hi_run = 0;
         end
         if (!ee_cs && ee_sk) sk_viol++;
         if (ee_sk && p_sk && ee_di != p_di) di_viol++;
         p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [31:0] frame;
      int          nbits;
      int          rises;
      logic        prog;
      logic        err;
      logic [15:0] rd;
   } exp_t;

   exp_t exp_q [64];
   int wr_idx = 0;
   int drv_checks = 0, drv_errs = 0, mon_checks = 0, mon_errs = 0;
   logic [15:0] ref_mem [256];
   logic ref_wen = 1'b0;
   logic [15:0] last_rd = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      drv_checks++;
      if (!ok) begin
         drv_errs++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
      end
   endtask

   task automatic mchk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
      mon_checks++;
      if (!ok) begin
         mon_errs++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] build_frame(input logic [2:0] op, input logic [7:0] a,
                                               input logic [15:0] d, output int n);
      logic [31:0] v;
      n = 11;
      case (op)
         3'd0: v = 32'({1'b1, 2'b10, a});
         3'd1: begin v = 32'({1'b1, 2'b01, a, d}); n = 27; end
         3'd2: v = 32'({1'b1, 2'b11, a});
         3'd3: v = 32'({1'b1, 2'b00, 8'hC0});
         3'd5: v = 32'({1'b1, 2'b00, 8'h80});
         3'd6: begin v = 32'({1'b1, 2'b00, 8'h40, d}); n = 27; end
         default: v = 32'({1'b1, 2'b00, 8'h00});
      endcase
      return v;
   endfunction

   int rd_idx_m = 0, rise_base = 0;
   logic done_q = 1'b0;
   exp_t me;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done && done_q) mchk(1'b0, "R6", "done wider than one cycle", 32'd1, 32'd0);
         if (done) begin
            mchk(!busy, "R6", "busy with done", 32'(busy), 32'd0);
            if (rd_idx_m >= wr_idx) begin
               mchk(1'b0, "R7", "unexpected done", 32'(rd_idx_m), 32'(wr_idx));
            end else begin
               me = exp_q[rd_idx_m % 64];
               rd_idx_m++;
               mchk(last_rx == me.frame, "R1", "frame bits", last_rx, me.frame);
               mchk(last_n == me.nbits, "R9", "frame length", 32'(last_n), 32'(me.nbits));
               mchk(cs_rises - rise_base == me.rises, me.prog ? "R4" : "R8",
                    "chip-select rises", 32'(cs_rises - rise_base), 32'(me.rises));
               mchk(timeout_err == me.err, "R5", "timeout_err", 32'(timeout_err), 32'(me.err));
               mchk(rdata == me.rd, "R3", "rdata", 32'(rdata), 32'(me.rd));
            end
            rise_base = cs_rises;
         end
         done_q = done;
      end
   end

   // ---------------- driver ----------------
   task automatic run(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d,
                      input logic exp_err, input bit intrude);
      exp_t e;
      int n;
      e.frame = build_frame(op, a, d, n);
      e.nbits = n;
      e.prog  = (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
      e.rises = e.prog ? 2 : 1;
      e.err   = exp_err;
      case (op)
         3'd0: last_rd = ref_mem[a];
         3'd1: if (ref_wen) ref_mem[a] = d;
         3'd2: if (ref_wen) ref_mem[a] = 16'hFFFF;
         3'd3: ref_wen = 1'b1;
         3'd5: if (ref_wen) for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
         3'd6: if (ref_wen) for (int i = 0; i < 256; i++) ref_mem[i] = d;
         default: ref_wen = 1'b0;
      endcase
      e.rd = last_rd;
      exp_q[wr_idx % 64] = e;
      wr_idx++;
      op_i = op; addr_i = a; wdata_i = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         repeat (20) @(negedge clk);
         op_i = 3'd0; addr_i = 8'h00; start = 1'b1;   // R7: must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      stuck = 1'b0;
      for (int i = 0; i < 256; i++) ref_mem[i] = 16'(i) ^ 16'hA5C3;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ee_cs && !ee_sk, "R2", "reset cs/sk", {30'd0, ee_cs, ee_sk}, 32'd0);
      chk(!busy && !done, "R6", "reset busy/done", {30'd0, busy, done}, 32'd0);
      chk(!timeout_err, "R5", "reset timeout_err", 32'(timeout_err), 32'd0);
      chk(rdata == 16'h0, "R3", "reset rdata", 32'(rdata), 32'd0);

      run(3'd1, 8'h12, 16'h1234, 1'b0, 1'b0);   // write while device protected
      run(3'd0, 8'h12, 16'h0, 1'b0, 1'b0);
      run(3'd3, 8'h00, 16'h0, 1'b0, 1'b0);      // enable
      run(3'd1, 8'h12, 16'hBEEF, 1'b0, 1'b0);
      run(3'd0, 8'h12, 16'h0, 1'b0, 1'b0);
      run(3'd1, 8'hFF, 16'h8001, 1'b0, 1'b0);   // top address
      run(3'd0, 8'hFF, 16'h0, 1'b0, 1'b0);
      run(3'd2, 8'h12, 16'h0, 1'b0, 1'b0);      // erase
      run(3'd0, 8'h12, 16'h0, 1'b0, 1'b0);
      run(3'd6, 8'h00, 16'h5A5A, 1'b0, 1'b0);   // write all
      run(3'd0, 8'h00, 16'h0, 1'b0, 1'b0);
      run(3'd5, 8'h00, 16'h0, 1'b0, 1'b0);      // erase all
      run(3'd0, 8'h80, 16'h0, 1'b0, 1'b0);
      run(3'd4, 8'h00, 16'h0, 1'b0, 1'b0);      // disable
      run(3'd1, 8'h10, 16'h1111, 1'b0, 1'b0);
      run(3'd0, 8'h10, 16'h0, 1'b0, 1'b0);
      run(3'd7, 8'h3C, 16'h0, 1'b0, 1'b0);      // reserved code acts as disable
      stuck = 1'b1;                              // R5: device never ready
      run(3'd1, 8'h44, 16'h4444, 1'b1, 1'b0);
      stuck = 1'b0;
      run(3'd0, 8'h10, 16'h0, 1'b0, 1'b0);      // error clears on next op
      run(3'd3, 8'h00, 16'h0, 1'b0, 1'b0);
      run(3'd1, 8'h33, 16'h7777, 1'b0, 1'b1);   // R7 intruding start
      run(3'd0, 8'h33, 16'h0, 1'b0, 1'b0);

      repeat (10) @(negedge clk);
      chk(rd_idx_m == wr_idx, "R7", "completions vs operations", 32'(rd_idx_m), 32'(wr_idx));
      chk(sk_viol == 0, "R2", "shift clock shape violations", 32'(sk_viol), 32'd0);
      chk(di_viol == 0, "R2", "data-in change while clock high", 32'(di_viol), 32'd0);
      $display("CHECKS %0d ERRORS %0d", drv_checks + mon_checks, drv_errs + mon_errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired act=%0d exp=%0d", rd_idx_m, wr_idx);
      $display("CHECKS %0d ERRORS %0d", drv_checks + mon_checks + 1, drv_errs + mon_errs + 1);
      $finish;
   end

endmodule